// File: doc/BRIEF.md
# Tagged Serial Register Access Engine

This block carries single register reads and writes from a requester to a codec behind a frame-based serial link. The link is seen as two words: a control word that the engine writes to launch a frame (target address, write flag, 16-bit data), and a status word that always reflects the address tag and data of the most recently completed frame. The serial framing itself sits elsewhere; this engine only sequences the control writes and status polls.

A read posts the target address in a control word and then samples the status word every cycle until its address tag equals the requested address. The whole matching status word goes back to the requester. A write always begins with that same address-matched read. Once the tag matches, the engine builds the write frame from the returned status word: it sets the write flag, replaces the data field with the saved write value and keeps every other bit. Polling is bounded, and a tag that never matches is reported as an error.

Top module: `srae_top`

## Requirements
- R1: After reset the engine is idle: req_ready is 1, and rsp_done, rsp_error, lnk_ctl_we and lnk_stat_rd are 0.
- R2: In the cycle after a request is accepted (req_valid high while req_ready is high), lnk_ctl_we is high for one cycle. lnk_ctl_word then carries the requested address in bits [30:27], and every other bit is 0.
- R3: From the cycle after that post, lnk_stat_rd is high in every cycle up to and including the first cycle in which bits [30:27] of lnk_stat_word equal the requested address.
- R4: A read completes in the cycle after the matching poll. rsp_done is high for exactly one cycle, rsp_error is 0, and rsp_rdata holds the entire 32-bit matching status word.
- R5: Polling stops after 200 attempts. If all 200 polls mismatch, rsp_done and rsp_error are both 1 in the cycle after the 200th poll, and no write frame is issued. A match on the 200th poll still succeeds.
- R6: A write performs the R2/R3 read on the same address. In the cycle after the match, lnk_ctl_we is high with a word equal to the matching status word with bit 26 set and bits [15:0] replaced by the write data. rsp_done (with rsp_error 0) follows one cycle later, and rsp_rdata then holds the matching status word.
- R7: Only bits [15:0] of req_wdata reach the write frame. Bits [31:16] have no effect.
- R8: req_ready is low from the cycle after acceptance until the cycle in which rsp_done rises. A req_valid raised while req_ready is low is ignored: it causes no control write and does not change the address being served.
- R9: lnk_ctl_we and lnk_stat_rd are never high in the same cycle, and rsp_done is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Codec register address |
| req_wdata | input | 32 | Write value; only bits [15:0] are used |
| req_ready | output | 1 | Engine idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Poll limit reached; valid with rsp_done |
| rsp_rdata | output | 32 | Matching status word |
| lnk_ctl_we | output | 1 | Control word write strobe |
| lnk_ctl_word | output | 32 | Control word to the link |
| lnk_stat_rd | output | 1 | Status word sample strobe |
| lnk_stat_word | input | 32 | Status word from the link |

## Verification
A wrong state or a wrong captured address shows up first on the link. If the posted control word carries a bad tag, the mismatch is visible one cycle after acceptance. If the poll never ends, or ends early, the count of lnk_stat_rd cycles is wrong and rsp_done arrives on the wrong cycle. The bench drives a link model whose match latency is swept across 0, mid-range, exactly 199 and above the limit, so an off-by-one in the attempt counter shifts the done cycle or flips rsp_error. A write frame that is assembled wrongly (wrong flag, stale data, leaked upper write bits) is compared bit for bit on the single control write that follows the match.

// File: rtl/srae_pkg.sv
package srae_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_POST  = 2'd1,
      SEQ_POLL  = 2'd2,
      SEQ_WRITE = 2'd3
   } seq_state_t;

   // ceiling log2 with a floor of one bit for counters
   function automatic int cnt_width(input int limit);
      int w;
      w = 1;
      while ((1 << w) < limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/srae_frame_fmt.sv
module srae_frame_fmt #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int ADDR_LSB  = 27,
   parameter int WFLAG_BIT = 26,
   parameter int DATA_W    = 16
) (
   input  logic [ADDR_W-1:0] post_addr,
   input  logic [WORD_W-1:0] stat_word,
   input  logic [WORD_W-1:0] held_word,
   input  logic [DATA_W-1:0] new_data,
   output logic [WORD_W-1:0] post_word,
   output logic [WORD_W-1:0] write_word,
   output logic [ADDR_W-1:0] stat_tag
);

   localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

   // elaboration-time layout checks
   if (ADDR_MSB >= WORD_W) begin : g_chk_addr
      $error("address field exceeds word width");
   end
   if (DATA_W > ADDR_LSB) begin : g_chk_data
      $error("data field overlaps address field");
   end
   if (WFLAG_BIT < DATA_W || (WFLAG_BIT >= ADDR_LSB && WFLAG_BIT <= ADDR_MSB)
       || WFLAG_BIT >= WORD_W) begin : g_chk_flag
      $error("write flag collides with another field");
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      // posted read frame: tag only, all else zero
      if (b >= ADDR_LSB && b <= ADDR_MSB) begin : g_post_tag
         assign post_word[b] = post_addr[b-ADDR_LSB];
      end else begin : g_post_zero
         assign post_word[b] = 1'b0;
      end
      // write frame: returned word, flag forced, data replaced
      if (b < DATA_W) begin : g_wr_data
         assign write_word[b] = new_data[b];
      end else if (b == WFLAG_BIT) begin : g_wr_flag
         assign write_word[b] = 1'b1;
      end else begin : g_wr_keep
         assign write_word[b] = held_word[b];
      end
   end

   assign stat_tag = stat_word[ADDR_LSB +: ADDR_W];

endmodule

// File: rtl/srae_poll_ctr.sv
module srae_poll_ctr #(
   parameter int LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);

   localparam int CW = srae_pkg::cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_chk_limit
      $error("poll limit must be at least one");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // attempt number cnt_q+1 is under way; the last one is LIMIT
   assign last = (cnt_q == LAST_VAL);

   // R5: counter stays inside the attempt window
   assert_poll_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt_q <= LAST_VAL));

endmodule

// File: rtl/srae_seq.sv
module srae_seq
   import srae_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic tag_match,
   input  logic poll_last,
   output logic ready,
   output logic accept,
   output logic post_go,
   output logic poll_go,
   output logic write_go,
   output logic cnt_clear,
   output logic cnt_step,
   output logic capture,
   output logic finish_ok,
   output logic finish_err
);

   seq_state_t state_q, state_d;
   logic       wr_q;

   always_comb begin
      state_d    = state_q;
      ready      = 1'b0;
      post_go    = 1'b0;
      poll_go    = 1'b0;
      write_go   = 1'b0;
      cnt_clear  = 1'b0;
      cnt_step   = 1'b0;
      capture    = 1'b0;
      finish_ok  = 1'b0;
      finish_err = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            ready = 1'b1;
            if (req_valid) state_d = SEQ_POST;
         end
         SEQ_POST: begin
            post_go   = 1'b1;
            cnt_clear = 1'b1;
            state_d   = SEQ_POLL;
         end
         SEQ_POLL: begin
            poll_go = 1'b1;
            if (tag_match) begin
               capture = 1'b1;
               if (wr_q) begin
                  state_d = SEQ_WRITE;
               end else begin
                  finish_ok = 1'b1;
                  state_d   = SEQ_IDLE;
               end
            end else if (poll_last) begin
               finish_err = 1'b1;
               state_d    = SEQ_IDLE;
            end else begin
               cnt_step = 1'b1;
            end
         end
         SEQ_WRITE: begin
            write_go  = 1'b1;
            finish_ok = 1'b1;
            state_d   = SEQ_IDLE;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   assign accept = ready & req_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) wr_q <= req_write;
      end
   end

   // R6: a write frame only ever follows a matching poll
   assert_write_after_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      write_go |-> $past(capture));

endmodule

// File: rtl/srae_top.sv
module srae_top #(
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int ADDR_LSB   = 27,
   parameter int WFLAG_BIT  = 26,
   parameter int DATA_W     = 16,
   parameter int WDATA_W    = 32,
   parameter int POLL_LIMIT = 200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WDATA_W-1:0] req_wdata,
   output logic               req_ready,
   output logic               rsp_done,
   output logic               rsp_error,
   output logic [WORD_W-1:0]  rsp_rdata,
   output logic               lnk_ctl_we,
   output logic [WORD_W-1:0]  lnk_ctl_word,
   output logic               lnk_stat_rd,
   input  logic [WORD_W-1:0]  lnk_stat_word
);

   if (WDATA_W < DATA_W) begin : g_chk_wdata
      $error("request data narrower than frame data field");
   end

   logic              accept, post_go, poll_go, write_go;
   logic              cnt_clear, cnt_step, poll_last, capture;
   logic              finish_ok, finish_err, tag_match;
   logic [ADDR_W-1:0] addr_q, stat_tag;
   logic [DATA_W-1:0] wdata_q;
   logic [WORD_W-1:0] held_q, post_word, write_word;

   srae_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .tag_match  (tag_match),
      .poll_last  (poll_last),
      .ready      (req_ready),
      .accept     (accept),
      .post_go    (post_go),
      .poll_go    (poll_go),
      .write_go   (write_go),
      .cnt_clear  (cnt_clear),
      .cnt_step   (cnt_step),
      .capture    (capture),
      .finish_ok  (finish_ok),
      .finish_err (finish_err)
   );

   srae_poll_ctr #(.LIMIT(POLL_LIMIT)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cnt_clear),
      .step  (cnt_step),
      .last  (poll_last)
   );

   srae_frame_fmt #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .ADDR_LSB  (ADDR_LSB),
      .WFLAG_BIT (WFLAG_BIT),
      .DATA_W    (DATA_W)
   ) u_fmt (
      .post_addr  (addr_q),
      .stat_word  (lnk_stat_word),
      .held_word  (held_q),
      .new_data   (wdata_q),
      .post_word  (post_word),
      .write_word (write_word),
      .stat_tag   (stat_tag)
   );

   assign tag_match = (stat_tag == addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wdata_q   <= '0;
         held_q    <= '0;
         rsp_done  <= 1'b0;
         rsp_error <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata[DATA_W-1:0];
         end
         if (capture) held_q <= lnk_stat_word;
         rsp_done  <= finish_ok | finish_err;
         rsp_error <= finish_err;
      end
   end

   assign rsp_rdata    = held_q;
   assign lnk_ctl_we   = post_go | write_go;
   assign lnk_ctl_word = write_go ? write_word : post_word;
   assign lnk_stat_rd  = poll_go;

   // R2: acceptance is followed by a tag-only post of the same address
   assert_post_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (lnk_ctl_we && !lnk_ctl_word[WFLAG_BIT]
         && lnk_ctl_word[ADDR_LSB +: ADDR_W] == $past(req_addr)));

   // R4: completion is a single-cycle pulse
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R5: an error is reported only with done, right after a failing poll
   assert_error_after_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> (rsp_done && $past(lnk_stat_rd) && !$past(lnk_ctl_we)));

   // R6: a write frame is followed by a clean completion
   assert_write_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_ctl_we && lnk_ctl_word[WFLAG_BIT]) |=> (rsp_done && !rsp_error));

   // R8: no second acceptance while a request is in flight
   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: link strobes are exclusive
   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(lnk_ctl_we && lnk_stat_rd));

endmodule

// File: tb/tb_srae_top.sv
module tb_srae_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   // vector table: write flag, address, write data, match latency,
   // status data field, expected error
   localparam logic        V_WR  [0:NV-1] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [3:0]  V_AD  [0:NV-1] = '{4'd3, 4'd15, 4'd0, 4'd9, 4'd6, 4'd7, 4'd12, 4'd5};
   localparam logic [31:0] V_WD  [0:NV-1] = '{32'h0, 32'h0, 32'hDEAD_BEEF, 32'h0000_5A5A,
                                             32'h0, 32'h0, 32'h1111_2222, 32'hFFFF_0001};
   localparam int          V_LAT [0:NV-1] = '{0, 5, 2, 0, 199, 250, 300, 10};
   localparam logic [15:0] V_SD  [0:NV-1] = '{16'hA5A5, 16'h1234, 16'h00FF, 16'hFFFF,
                                             16'h0F0F, 16'h7777, 16'h3C3C, 16'h8000};
   localparam logic        V_ERR [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_done, rsp_error;
   logic [31:0] rsp_rdata, lnk_ctl_word;
   logic        lnk_ctl_we, lnk_stat_rd;
   logic [31:0] lnk_stat_word;

   logic [31:0] match_w = '0;
   logic [31:0] miss_w = 32'h0800_0000;
   int          cur_lat = 0;
   int          polls = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   int          mon_bad = 0;
   int          ctl_writes = 0;
   logic        prev_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srae_top dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .req_ready     (req_ready),
      .rsp_done      (rsp_done),
      .rsp_error     (rsp_error),
      .rsp_rdata     (rsp_rdata),
      .lnk_ctl_we    (lnk_ctl_we),
      .lnk_ctl_word  (lnk_ctl_word),
      .lnk_stat_rd   (lnk_stat_rd),
      .lnk_stat_word (lnk_stat_word)
   );

   // link model: status tag matches after cur_lat polls since the last control write
   assign lnk_stat_word = (polls >= cur_lat) ? match_w : miss_w;

   always @(posedge clk) begin
      if (lnk_ctl_we) begin
         polls <= 0;
         ctl_writes <= ctl_writes + 1;
      end else if (lnk_stat_rd) begin
         polls <= polls + 1;
      end
   end

   // R9 monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (lnk_ctl_we && lnk_stat_rd) mon_bad++;
         if (rsp_done && prev_done) mon_bad++;
      end
      prev_done = rsp_done;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   task automatic run_req(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                          input int lat, input logic [15:0] sd, input logic exp_err);
      logic [31:0] mw, frame, exp_frame;
      int k, seen, nwr, exp_p, exp_k;
      mw = {1'b0, a, 11'h0C3, sd};
      match_w = mw;
      miss_w = {1'b0, a ^ 4'h1, 11'h0C3, sd};
      cur_lat = lat;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(lnk_ctl_we && lnk_ctl_word == {1'b0, a, 27'h0}, "R2 post word",
          lnk_ctl_word, {1'b0, a, 27'h0});
      k = 1; seen = 0; nwr = 0; frame = '0;
      while (!rsp_done && k < 400) begin
         @(negedge clk);
         k++;
         if (lnk_stat_rd) seen++;
         if (lnk_ctl_we) begin nwr++; frame = lnk_ctl_word; end
      end
      exp_p = (lat >= 200) ? 200 : lat + 1;
      exp_k = 2 + exp_p + ((wr && !exp_err) ? 1 : 0);
      chk(seen == exp_p, exp_err ? "R5 poll count" : "R3 poll count", seen, exp_p);
      chk(k == exp_k, "R4 done cycle", k, exp_k);
      chk(rsp_error == exp_err, "R5 error flag", {31'b0, rsp_error}, {31'b0, exp_err});
      if (!exp_err) chk(rsp_rdata == mw, "R4 read data", rsp_rdata, mw);
      if (wr && !exp_err) begin
         exp_frame = {mw[31:27], 1'b1, mw[25:16], wd[15:0]};
         chk(nwr == 1 && frame == exp_frame, "R6 R7 write frame", frame, exp_frame);
      end else begin
         chk(nwr == 0, exp_err ? "R5 no write frame" : "R4 no extra frame", nwr, 0);
      end
      @(negedge clk);
      chk(!rsp_done, "R9 done single pulse", {31'b0, rsp_done}, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int w0;
      logic [31:0] mw2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !rsp_done && !rsp_error && !lnk_ctl_we && !lnk_stat_rd,
          "R1 idle after reset",
          {27'b0, req_ready, rsp_done, rsp_error, lnk_ctl_we, lnk_stat_rd}, 32'h10);

      for (int i = 0; i < NV; i++) begin
         run_req(V_WR[i], V_AD[i], V_WD[i], V_LAT[i], V_SD[i], V_ERR[i]);
      end

      // R8: requests while busy are ignored
      mw2 = {1'b0, 4'd2, 11'h0C3, 16'hBEEF};
      match_w = mw2; miss_w = {1'b0, 4'd3, 11'h0C3, 16'hBEEF}; cur_lat = 3;
      @(negedge clk);
      w0 = ctl_writes;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd2;
      @(negedge clk);
      chk(!req_ready, "R8 ready low when busy", {31'b0, req_ready}, 32'h0);
      req_write = 1'b1; req_addr = 4'd11; req_wdata = 32'h0000_1234;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_done) @(negedge clk);
      chk(req_ready, "R8 ready back at done", {31'b0, req_ready}, 32'h1);
      chk(ctl_writes - w0 == 1, "R8 single control write", ctl_writes - w0, 1);
      chk(rsp_rdata == mw2 && !rsp_error, "R8 served address kept", rsp_rdata, mw2);
      repeat (3) @(negedge clk);
      chk(ctl_writes - w0 == 1, "R8 no late post", ctl_writes - w0, 1);

      // R1 again: reset mid-poll returns to idle
      match_w = 32'h0; miss_w = 32'h0800_0000; cur_lat = 1000;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !lnk_stat_rd && !rsp_done, "R1 idle after mid-poll reset",
          {29'b0, req_ready, lnk_stat_rd, rsp_done}, 32'h4);

      chk(mon_bad == 0, "R9 strobe exclusivity and done pulse", mon_bad, 0);
      summary();
   end

endmodule